// File: doc/BRIEF.md
# Supply Brown-out Reset Sequencer

This block is the digital timing stage of a supply supervisor. An external comparator raises a flag while the supply sits under its trip point. The flag enters a two-stage synchroniser and then a minimum-duration filter. The filter discards short dips. Only a dip that persists for `DIP_MIN_CYCLES` consecutive clocks counts as a real brown-out.

A small state machine drives the system reset. The reset is held for as long as a qualified dip lasts. When the supply recovers, a hold timer starts, and the reset is held for `HOLD_CYCLES` further clocks. With the defaults (`CLK_HZ` = 1 MHz) the hold is 240 ms. A qualified dip that arrives while the timer is running restarts the whole hold. A status output shows when the hold timer is counting. The `ACTIVE_LOW` parameter sets the reset polarity at build time.

The state machine has four states:
- `ST_POR`: held while the block's own reset input is low.
- `ST_HOLD`: the recovery timer is running.
- `ST_FAULT`: the supply is low.
- `ST_RUN`: the reset is released.

The transitions are:
- POR→HOLD on the first clock after reset release.
- HOLD→FAULT and RUN→FAULT on a qualified dip.
- FAULT→HOLD when the qualified dip ends.
- HOLD→RUN when the timer expires.

Top module: `brownout_reset_seq`

## Requirements
- R1: While `rst_ni` is low, the reset output is asserted and `hold_busy_o` is 0. After release, `hold_busy_o` is 1 from the first rising edge. The reset is released, with `hold_busy_o` back to 0, on rising edge `HOLD_CYCLES`+1 after release.
- R2: A high pulse on `supply_low_i` sampled on fewer than `DIP_MIN_CYCLES` consecutive rising edges has no effect on the outputs. This holds both while the reset is released and while the hold timer runs, and the timer's end edge does not move.
- R3: When `supply_low_i` is sampled high on `DIP_MIN_CYCLES` or more consecutive edges, the reset asserts on edge `DIP_MIN_CYCLES`+3, counting the first high sample as edge 1. Edge `DIP_MIN_CYCLES`+2 still shows the previous output.
- R4: While a qualified dip lasts, the reset stays asserted and `hold_busy_o` stays 0.
- R5: If the last high sample of a qualified dip is edge L, `hold_busy_o` rises on edge L+4. The reset is released, with `hold_busy_o` low, on edge L+4+`HOLD_CYCLES`.
- R6: A qualified dip during the hold drops `hold_busy_o` at the assertion edge of R3. The full `HOLD_CYCLES` then restart from the end of that dip, so the earlier end point no longer releases the reset.
- R7: With `ACTIVE_LOW`=1, `sys_rst_o` is 0 while asserted. With `ACTIVE_LOW`=0, it is 1 while asserted.
- R8: `hold_busy_o` is never 1 while the reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock; all timeouts are counted in its cycles |
| rst_ni | input | 1 | Asynchronous active-low power-on reset of the block |
| supply_low_i | input | 1 | Comparator flag, high while the supply is below threshold |
| sys_rst_o | output | 1 | System reset, polarity set by `ACTIVE_LOW` |
| hold_busy_o | output | 1 | High while the post-recovery timer is counting |

## Verification
The bench builds two copies with `HOLD_CYCLES`=40 and `DIP_MIN_CYCLES`=6, one with each polarity. Both copies share the same stimulus. The short hold makes the exact release edges reachable and checkable, including a restarted hold, within a few hundred cycles. The filter length of 6 allows dips of exactly 5 and exactly 6 samples to be applied, which probes both sides of the qualification boundary.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [1:0] {
        ST_POR   = 2'd0,
        ST_FAULT = 2'd1,
        ST_HOLD  = 2'd2,
        ST_RUN   = 2'd3
    } brs_state_t;

    function automatic int brs_cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[0] <= 1'b0;
                    else         stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[s] <= 1'b0;
                    else         stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/brs_dip_filter.sv
module brs_dip_filter
    import brs_pkg::*;
#(
    parameter int MIN_CYCLES = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic low_i,
    output logic sustained_o
);
    localparam int CW = brs_cnt_width(MIN_CYCLES);
    localparam logic [CW-1:0] SAT = CW'(MIN_CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          sus_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
            sus_q <= 1'b0;
        end else if (!low_i) begin
            run_q <= '0;
            sus_q <= 1'b0;
        end else begin
            if (run_q != SAT) run_q <= run_q + 1'b1;
            sus_q <= (run_q == SAT);
        end
    end

    assign sustained_o = sus_q;
endmodule

// File: rtl/brs_hold_timer.sv
module brs_hold_timer
    import brs_pkg::*;
#(
    parameter int HOLD_CYCLES = 240000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expire_o
);
    localparam int TW = brs_cnt_width(HOLD_CYCLES);
    localparam logic [TW-1:0] LAST = TW'(HOLD_CYCLES - 1);

    logic [TW-1:0] tick_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              tick_q <= '0;
        else if (!run_i)          tick_q <= '0;
        else if (tick_q != LAST)  tick_q <= tick_q + 1'b1;
    end

    assign expire_o = run_i && (tick_q == LAST);
endmodule

// File: rtl/brownout_reset_seq.sv
module brownout_reset_seq
    import brs_pkg::*;
#(
    parameter int CLK_HZ         = 1_000_000,
    parameter int HOLD_MS        = 240,
    parameter int HOLD_CYCLES    = (CLK_HZ / 1000) * HOLD_MS,
    parameter int DIP_MIN_CYCLES = 5,
    parameter int SYNC_STAGES    = 2,
    parameter bit ACTIVE_LOW     = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic supply_low_i,
    output logic sys_rst_o,
    output logic hold_busy_o
);
    brs_state_t state_q, state_d;
    logic       low_sync;
    logic       dip_sustained;
    logic       hold_expire;
    logic       rst_act_q;
    logic       busy_q;

    brs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (supply_low_i),
        .sync_o  (low_sync)
    );

    brs_dip_filter #(.MIN_CYCLES(DIP_MIN_CYCLES)) u_filter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .low_i       (low_sync),
        .sustained_o (dip_sustained)
    );

    brs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (state_q == ST_HOLD),
        .expire_o (hold_expire)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR:   state_d = ST_HOLD;
            ST_HOLD: begin
                if (dip_sustained)    state_d = ST_FAULT;
                else if (hold_expire) state_d = ST_RUN;
            end
            ST_FAULT: if (!dip_sustained) state_d = ST_HOLD;
            ST_RUN:   if (dip_sustained)  state_d = ST_FAULT;
            default:  state_d = ST_POR;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_POR;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rst_act_q <= 1'b1;
            busy_q    <= 1'b0;
        end else begin
            rst_act_q <= (state_d != ST_RUN);
            busy_q    <= (state_d == ST_HOLD);
        end
    end

    generate
        if (ACTIVE_LOW) begin : g_pol_low
            assign sys_rst_o = ~rst_act_q;
        end else begin : g_pol_high
            assign sys_rst_o = rst_act_q;
        end
    endgenerate

    assign hold_busy_o = busy_q;
endmodule

// File: rtl/brownout_reset_seq_chk.sv
module brownout_reset_seq_chk #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input logic clk_i,
    input logic rst_ni,
    input logic sys_rst_o,
    input logic hold_busy_o,
    input logic sustained_i
);
    logic rst_act;
    assign rst_act = ACTIVE_LOW ? ~sys_rst_o : sys_rst_o;

    a_r1_por_held: assert property (@(posedge clk_i)
        !rst_ni |-> (rst_act && !hold_busy_o));

    a_r8_busy_needs_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_busy_o |-> rst_act);

    a_r4_dip_holds_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sustained_i |=> (rst_act && !hold_busy_o));

    a_r5_release_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_act) |-> $past(hold_busy_o));

    a_r3_assert_needs_dip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_act) |-> $past(sustained_i));

    a_r6_dip_restarts_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sustained_i && hold_busy_o) |=> !hold_busy_o);
endmodule

bind brownout_reset_seq brownout_reset_seq_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sys_rst_o   (sys_rst_o),
    .hold_busy_o (hold_busy_o),
    .sustained_i (dip_sustained)
);

// File: tb/brownout_reset_seq_test.sv
`timescale 1ns/1ps
module brownout_reset_seq_test;
    localparam int H = 40;
    localparam int G = 6;

    typedef struct {
        int    cyc;
        bit    act;
        bit    busy;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_ni = 1'b1;
    logic supply_low = 1'b0;
    logic rst_lo, busy_lo, rst_hi, busy_hi;
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    brownout_reset_seq #(.HOLD_CYCLES(H), .DIP_MIN_CYCLES(G), .ACTIVE_LOW(1'b1)) uut (
        .clk_i(clk), .rst_ni(rst_ni), .supply_low_i(supply_low),
        .sys_rst_o(rst_lo), .hold_busy_o(busy_lo));

    brownout_reset_seq #(.HOLD_CYCLES(H), .DIP_MIN_CYCLES(G), .ACTIVE_LOW(1'b0)) uut_hi (
        .clk_i(clk), .rst_ni(rst_ni), .supply_low_i(supply_low),
        .sys_rst_o(rst_hi), .hold_busy_o(busy_hi));

    function automatic void expect_at(int c, bit act, bit busy, string tag);
        exp_t e;
        e.cyc = c; e.act = act; e.busy = busy; e.tag = tag;
        q.push_back(e);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    // monitor: pops scoreboard items at the cycle they name
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            if (e.cyc < cyc) begin
                check(e.tag, "missed sample", cyc, e.cyc);
            end else begin
                check(e.tag, "active-low reset", int'(rst_lo), int'(!e.act));
                check("R7", "active-high reset", int'(rst_hi), int'(e.act));
                check(e.tag, "hold busy", int'(busy_lo), int'(e.busy));
                check("R8", "busy without reset", int'(busy_lo && rst_lo), 0);
            end
        end
    end

    task automatic go_to(int c);
        while (cyc < c) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic raise_flag(int len);
        supply_low = 1'b1;
        repeat (len) @(posedge clk);
        #2;
        supply_low = 1'b0;
    endtask

    // qualified dip of length len (>= G) starting with reset released
    task automatic dip_from_run(int len, string tag);
        int n;
        n = cyc;
        expect_at(n + G + 2, 1'b0, 1'b0, "R3");
        expect_at(n + G + 3, 1'b1, 1'b0, "R3");
        if (len > G) expect_at(n + len + 3, 1'b1, 1'b0, "R4");
        expect_at(n + len + 4, 1'b1, 1'b1, "R5");
        expect_at(n + len + 3 + H, 1'b1, 1'b1, tag);
        expect_at(n + len + 4 + H, 1'b0, 1'b0, tag);
        raise_flag(len);
        go_to(n + len + H + 8);
    endtask

    task automatic short_dip_from_run(int len);
        int n;
        n = cyc;
        for (int k = 1; k <= len + G + 6; k++) expect_at(n + k, 1'b0, 1'b0, "R2");
        raise_flag(len);
        go_to(n + len + G + 8);
    endtask

    // dip during hold: qualified restarts (R6), short leaves end edge (R2)
    task automatic dip_in_hold(int len2, string tag);
        int n, m;
        n = cyc;
        expect_at(n + 13, 1'b1, 1'b0, "R3");
        expect_at(n + 14, 1'b1, 1'b1, "R5");
        raise_flag(10);
        m = n + 30;
        if (len2 >= G) begin
            expect_at(m + G + 2, 1'b1, 1'b1, tag);
            expect_at(m + G + 3, 1'b1, 1'b0, tag);
            expect_at(m + G + 4, 1'b1, 1'b1, tag);
            expect_at(n + 14 + H, 1'b1, 1'b1, tag);
            expect_at(m + G + 3 + H, 1'b1, 1'b1, tag);
            expect_at(m + G + 4 + H, 1'b0, 1'b0, tag);
        end else begin
            expect_at(m + len2 + 4, 1'b1, 1'b1, tag);
            expect_at(n + 13 + H, 1'b1, 1'b1, tag);
            expect_at(n + 14 + H, 1'b0, 1'b0, tag);
        end
        go_to(m);
        raise_flag(len2);
        go_to(m + len2 + H + 12);
    endtask

    initial begin
        #1 rst_ni = 1'b0;
        expect_at(2, 1'b1, 1'b0, "R1");
        expect_at(3, 1'b1, 1'b0, "R1");
        go_to(4);
        rst_ni = 1'b1;
        expect_at(5, 1'b1, 1'b1, "R1");
        expect_at(4 + H, 1'b1, 1'b1, "R1");
        expect_at(5 + H, 1'b0, 1'b0, "R1");
        go_to(H + 10);
        short_dip_from_run(G - 1);
        short_dip_from_run(1);
        dip_from_run(G, "R5");
        dip_from_run(60, "R4");
        dip_in_hold(G, "R6");
        dip_in_hold(G - 1, "R2");
        go_to(cyc + 4);
        if (q.size() != 0) check("R1", "scoreboard drained", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule